// File: doc/BRIEF.md
# SPI Debug Byte-Stream Command Handler

This block is an SPI slave that lets a host exchange raw bytes with two debug byte FIFOs. The host opens every transaction by pulling chip select low and shifting in a one-byte opcode. The opcode fixes what the rest of that chip-select frame means. The block can send back a 32-bit snapshot of both FIFO fill levels. It can stream every following byte into the console-bound FIFO. It can stream the head of the host-bound FIFO out on MISO. It can also flush all FIFOs. Any other opcode turns the rest of the frame into a silent discard.

The SPI pins are sampled in the system clock domain through a two-stage synchronizer. The SPI clock must therefore have a high and a low phase of at least five system clocks each. The FIFOs sit outside the block. The console-bound FIFO takes a push strobe with a data byte and reports a full flag. The host-bound FIFO shows its head byte on a data input, reports an empty flag and takes a pop strobe.

The controller has six states:
- ST_IDLE: chip select is high.
- ST_OPCODE: a frame has opened and the opcode byte is being received.
- ST_STATUS: the status word is being returned.
- ST_PUSH: incoming bytes go to the console-bound FIFO.
- ST_POP: bytes are drawn from the host-bound FIFO.
- ST_DISCARD: the rest of the frame is ignored.

Transitions:
- ST_IDLE moves to ST_OPCODE on the falling edge of chip select.
- When the opcode byte completes, ST_OPCODE moves to one of four states: ST_STATUS on 0x60, ST_PUSH on 0x70, ST_POP on 0x80, and ST_DISCARD on 0xFF or on any unknown code.
- Every state returns to ST_IDLE on the rising edge of chip select.

Top module: `dbgspi_cmd_handler`

## Requirements
- R1: The SPI link works in mode 0. MOSI is taken on the rising SCK edge and MISO changes after the falling edge. Both directions carry the most significant bit first. MISO is 0 while chip select is high.
- R2: Opcode 0x60 returns a 32-bit word on bytes 1 to 4, most significant byte first. The word has zeros in bits 31:22, the console-bound level in bits 21:11 and the host-bound level in bits 10:0. Both levels are captured when the opcode byte completes. Bytes after the fourth return 0x00.
- R3: Under opcode 0x70, every complete byte after the opcode is pushed with its value into the console-bound FIFO, for as many bytes as the frame holds.
- R4: A byte received under 0x70 while the full flag is set is dropped without a push strobe.
- R5: Under opcode 0x80, each byte sent on MISO after the opcode is the FIFO head. It is popped once all eight of its bits have been clocked out.
- R6: Under 0x80, a byte slot that begins while the FIFO is empty returns 0x00 and causes no pop.
- R7: MOSI data during status and pop frames causes no push.
- R8: Opcode 0xFF produces a single-cycle flush strobe. The rest of that frame is ignored, with MISO at 0.
- R9: An unknown opcode leaves the rest of the frame without push, pop or flush, and MISO stays 0.
- R10: Raising chip select aborts the frame. A partial byte causes no push or pop, and the next frame starts again with an opcode.
- R11: At most one of push, pop and flush is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock from the host |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| dtx_push | output | 1 | Push strobe to the console-bound FIFO |
| dtx_data | output | 8 | Byte pushed to the console-bound FIFO |
| dtx_full | input | 1 | Console-bound FIFO is full |
| drx_pop | output | 1 | Pop strobe to the host-bound FIFO |
| drx_data | input | 8 | Head byte of the host-bound FIFO |
| drx_empty | input | 1 | Host-bound FIFO is empty |
| dtx_level | input | 11 | Bytes waiting in the console-bound FIFO |
| drx_level | input | 11 | Bytes waiting in the host-bound FIFO |
| fifo_flush | output | 1 | Flush strobe for all data and debug FIFOs |

## Verification
Five properties are checked on every cycle:
- MISO stays quiet outside a frame.
- No push happens into a full FIFO.
- No pop happens from an empty FIFO.
- The flush strobe lasts one cycle.
- No strobe appears while chip select is high, and at most one strobe appears per cycle.

The remaining behaviour only shows across whole SPI scenarios. That covers the status word contents and byte order, and when the levels are captured. It also covers the pushed byte values, the bytes popped and the zero fill when the FIFO runs dry, the effect of MOSI during read frames, and what survives an aborted frame. The bench sweeps twelve level pairs through the status opcode and drives a model of both FIFOs for these scenarios.

// File: rtl/dbgspi_pkg.sv
package dbgspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_STATUS,
        ST_PUSH,
        ST_POP,
        ST_DISCARD
    } dbgspi_state_e;

    localparam logic [7:0] OP_STATUS = 8'h60;
    localparam logic [7:0] OP_PUSH   = 8'h70;
    localparam logic [7:0] OP_POP    = 8'h80;
    localparam logic [7:0] OP_RESET  = 8'hFF;

endpackage

// File: rtl/dbgspi_sync.sv
module dbgspi_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dbgspi_shifter.sv
module dbgspi_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              cs_n_s,
    output logic              frame_start,
    output logic              frame_end,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              miso
);

    localparam int              BIT_W    = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic              sck_q;
    logic              cs_q;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              active;
    logic              rise;
    logic              fall;

    assign active      = ~cs_n_s;
    assign rise        = sck_s & ~sck_q;
    assign fall        = ~sck_s & sck_q;
    assign frame_start = cs_q & ~cs_n_s;
    assign frame_end   = ~cs_q & cs_n_s;

    // a new byte is loaded when the frame opens and on the falling edge after a full byte
    assign tx_load  = frame_start | (active & fall & (bit_cnt == '0));
    assign rx_valid = active & rise & (bit_cnt == LAST_BIT);
    assign rx_byte  = {rx_sh[BYTE_W-2:0], mosi_s};
    assign miso     = active & tx_sh[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
            if (!active) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
                tx_sh   <= '0;
            end else begin
                if (rise) begin
                    rx_sh   <= rx_byte;
                    bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                end
                if (tx_load) begin
                    tx_sh <= tx_byte;
                end else if (fall) begin
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/dbgspi_ctrl.sv
module dbgspi_ctrl
    import dbgspi_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int CNT_W    = 11,
    parameter int STATUS_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              dtx_push,
    output logic [BYTE_W-1:0] dtx_data,
    input  logic              dtx_full,
    output logic              drx_pop,
    input  logic [BYTE_W-1:0] drx_data,
    input  logic              drx_empty,
    input  logic [CNT_W-1:0]  dtx_level,
    input  logic [CNT_W-1:0]  drx_level,
    output logic              fifo_flush
);

    localparam int PAD_W = STATUS_W - 2 * CNT_W;

    dbgspi_state_e        state_q;
    dbgspi_state_e        state_d;
    logic [STATUS_W-1:0]  status_q;
    logic                 took_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (frame_end) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (frame_start) state_d = ST_OPCODE;
                end
                ST_OPCODE: begin
                    if (rx_valid) begin
                        case (rx_byte)
                            OP_STATUS: state_d = ST_STATUS;
                            OP_PUSH:   state_d = ST_PUSH;
                            OP_POP:    state_d = ST_POP;
                            default:   state_d = ST_DISCARD;
                        endcase
                    end
                end
                ST_STATUS, ST_PUSH, ST_POP, ST_DISCARD: state_d = state_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_byte    = '0;
        dtx_push   = 1'b0;
        drx_pop    = 1'b0;
        fifo_flush = 1'b0;
        dtx_data   = rx_byte;
        unique case (state_q)
            ST_IDLE:    ;
            ST_OPCODE:  fifo_flush = rx_valid & (rx_byte == OP_RESET);
            ST_STATUS:  tx_byte    = status_q[STATUS_W-1 -: BYTE_W];
            ST_PUSH:    dtx_push   = rx_valid & ~dtx_full;
            ST_POP: begin
                tx_byte = drx_empty ? '0 : drx_data;
                drx_pop = rx_valid & took_q;
            end
            ST_DISCARD: ;
        endcase
    end

    // status snapshot and pop bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            took_q   <= 1'b0;
        end else begin
            if (state_q == ST_OPCODE && rx_valid) begin
                status_q <= {{PAD_W{1'b0}}, dtx_level, drx_level};
            end else if (state_q == ST_STATUS && tx_load) begin
                status_q <= status_q << BYTE_W;
            end
            if (state_q != ST_POP || frame_end) begin
                took_q <= 1'b0;
            end else if (tx_load) begin
                took_q <= ~drx_empty;
            end
        end
    end

endmodule

// File: rtl/dbgspi_cmd_handler.sv
module dbgspi_cmd_handler #(
    parameter int BYTE_W      = 8,
    parameter int CNT_W       = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              dtx_push,
    output logic [BYTE_W-1:0] dtx_data,
    input  logic              dtx_full,
    output logic              drx_pop,
    input  logic [BYTE_W-1:0] drx_data,
    input  logic              drx_empty,
    input  logic [CNT_W-1:0]  dtx_level,
    input  logic [CNT_W-1:0]  drx_level,
    output logic              fifo_flush
);

    localparam int STATUS_W = 32;

    logic [2:0]        pins_s;
    logic              sck_s;
    logic              cs_n_s;
    logic              mosi_s;
    logic              frame_start;
    logic              frame_end;
    logic              rx_valid;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_byte;

    dbgspi_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck, spi_cs_n, spi_mosi}),
        .q     (pins_s)
    );

    assign sck_s  = pins_s[2];
    assign cs_n_s = pins_s[1];
    assign mosi_s = pins_s[0];

    dbgspi_shifter #(
        .BYTE_W (BYTE_W)
    ) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_s       (sck_s),
        .mosi_s      (mosi_s),
        .cs_n_s      (cs_n_s),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .tx_load     (tx_load),
        .tx_byte     (tx_byte),
        .miso        (spi_miso)
    );

    dbgspi_ctrl #(
        .BYTE_W   (BYTE_W),
        .CNT_W    (CNT_W),
        .STATUS_W (STATUS_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .tx_load     (tx_load),
        .tx_byte     (tx_byte),
        .dtx_push    (dtx_push),
        .dtx_data    (dtx_data),
        .dtx_full    (dtx_full),
        .drx_pop     (drx_pop),
        .drx_data    (drx_data),
        .drx_empty   (drx_empty),
        .dtx_level   (dtx_level),
        .drx_level   (drx_level),
        .fifo_flush  (fifo_flush)
    );

endmodule

// File: rtl/dbgspi_checker.sv
module dbgspi_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n_s,
    input logic spi_miso,
    input logic dtx_push,
    input logic dtx_full,
    input logic drx_pop,
    input logic drx_empty,
    input logic fifo_flush
);

    p_miso_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !spi_miso);

    p_push_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dtx_push |-> !dtx_full);

    p_pop_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drx_pop |-> !drx_empty);

    p_flush_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> !fifo_flush);

    p_frame_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !(dtx_push || drx_pop || fifo_flush));

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dtx_push, drx_pop, fifo_flush}) <= 1);

endmodule

bind dbgspi_cmd_handler dbgspi_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_s     (cs_n_s),
    .spi_miso   (spi_miso),
    .dtx_push   (dtx_push),
    .dtx_full   (dtx_full),
    .drx_pop    (drx_pop),
    .drx_empty  (drx_empty),
    .fifo_flush (fifo_flush)
);

// File: tb/test_dbgspi_cmd_handler.sv
`timescale 1ns/1ps
module test_dbgspi_cmd_handler;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        dtx_push;
    logic [7:0]  dtx_data;
    logic        dtx_full = 1'b0;
    logic        drx_pop;
    logic [7:0]  drx_data;
    logic        drx_empty;
    logic [10:0] dtx_level = '0;
    logic [10:0] drx_level = '0;
    logic        fifo_flush;

    always #4 clk = ~clk;

    dbgspi_cmd_handler i_dbgspi_cmd_handler (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .dtx_push(dtx_push),
        .dtx_data(dtx_data), .dtx_full(dtx_full), .drx_pop(drx_pop),
        .drx_data(drx_data), .drx_empty(drx_empty), .dtx_level(dtx_level),
        .drx_level(drx_level), .fifo_flush(fifo_flush)
    );

    // host-bound FIFO model
    logic [7:0] rxm [64];
    logic [5:0] rx_wr = '0;
    logic [5:0] rx_head = '0;
    assign drx_data  = rxm[rx_head];
    assign drx_empty = (rx_wr == rx_head);

    // strobe monitors
    logic [7:0] txlog [64];
    int push_n = 0, pop_n = 0, flush_n = 0, multi_n = 0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (dtx_push) begin txlog[push_n[5:0]] <= dtx_data; push_n <= push_n + 1; end
            if (drx_pop) begin rx_head <= rx_head + 1'b1; pop_n <= pop_n + 1; end
            if (fifo_flush) flush_n <= flush_n + 1;
            if (32'(dtx_push) + 32'(drx_pop) + 32'(fifo_flush) > 1) multi_n <= multi_n + 1;
        end
    end

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic halfwait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] b, input int n, output logic [7:0] r);
        r = '0;
        for (int i = 7; i >= 8 - n; i--) begin
            spi_mosi = b[i];
            halfwait();
            r[i] = spi_miso;
            spi_sck = 1'b1;
            halfwait();
            spi_sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        xfer_bits(b, 8, r);
    endtask

    task automatic open_frame();
        spi_cs_n = 1'b0;
        halfwait();
    endtask

    task automatic close_frame();
        halfwait();
        spi_cs_n = 1'b1;
        repeat (3) halfwait();
    endtask

    task automatic fill(input logic [7:0] v);
        @(negedge clk);
        rxm[rx_wr] = v;
        rx_wr = rx_wr + 1'b1;
    endtask

    initial begin
        logic [7:0]  r;
        logic [31:0] word;
        int p0, q0, f0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state
        check("R1 reset miso", 32'(spi_miso), 0);
        check("R11 reset strobes", 32'(push_n + pop_n + flush_n), 0);

        // R2 / R7: status sweep over twelve level pairs, MOSI carries push opcode
        for (int k = 0; k < 12; k++) begin
            logic [10:0] tl, rl;
            tl = 11'h7FF >> k;
            rl = ~tl ^ 11'(k * 3);
            dtx_level = tl;
            drx_level = rl;
            p0 = push_n;
            open_frame();
            xfer(8'h60, r);
            dtx_level = ~tl;
            drx_level = ~rl;
            word = '0;
            for (int j = 0; j < 4; j++) begin
                xfer(8'h70, r);
                word = {word[23:0], r};
            end
            xfer(8'h70, r);
            close_frame();
            check("R2 status word", word, {10'b0, tl, rl});
            check("R2 trailing byte", 32'(r), 0);
            check("R7 no push in status", 32'(push_n - p0), 0);
            check("R1 miso idle", 32'(spi_miso), 0);
        end

        // R3: push six bytes
        p0 = push_n;
        open_frame();
        xfer(8'h70, r);
        for (int i = 0; i < 6; i++) xfer(8'(8'h11 * i + 3), r);
        close_frame();
        check("R3 push count", 32'(push_n - p0), 6);
        for (int i = 0; i < 6; i++) check("R3 push value", 32'(txlog[6'(p0 + i)]), 32'(8'(8'h11 * i + 3)));

        // R4: full drops bytes
        p0 = push_n;
        dtx_full = 1'b1;
        open_frame();
        xfer(8'h70, r);
        for (int i = 0; i < 3; i++) xfer(8'hA0, r);
        check("R4 dropped while full", 32'(push_n - p0), 0);
        dtx_full = 1'b0;
        xfer(8'hB7, r);
        close_frame();
        check("R4 push after room", 32'(push_n - p0), 1);
        check("R4 push value", 32'(txlog[6'(p0)]), 32'h B7);

        // R5 / R7: pop four bytes while MOSI carries data
        for (int i = 0; i < 4; i++) fill(8'(8'hC0 + 7 * i));
        p0 = push_n; q0 = pop_n;
        open_frame();
        xfer(8'h80, r);
        for (int i = 0; i < 4; i++) begin
            xfer(8'h70, r);
            check("R5 pop value", 32'(r), 32'(8'(8'hC0 + 7 * i)));
        end
        close_frame();
        check("R5 pop count", 32'(pop_n - q0), 4);
        check("R5 fifo drained", 32'(drx_empty), 1);
        check("R7 no push in pop", 32'(push_n - p0), 0);

        // R6: pop past empty
        fill(8'h5A);
        q0 = pop_n;
        open_frame();
        xfer(8'h80, r);
        xfer(8'h00, r); check("R6 first real byte", 32'(r), 32'h5A);
        xfer(8'h00, r); check("R6 empty returns zero", 32'(r), 0);
        xfer(8'h00, r); check("R6 empty returns zero", 32'(r), 0);
        close_frame();
        check("R6 single pop", 32'(pop_n - q0), 1);

        // R8: reset opcode
        p0 = push_n; f0 = flush_n;
        open_frame();
        xfer(8'hFF, r);
        xfer(8'h70, r); check("R8 miso after flush", 32'(r), 0);
        xfer(8'h70, r);
        close_frame();
        check("R8 one flush", 32'(flush_n - f0), 1);
        check("R8 no push", 32'(push_n - p0), 0);

        // R9: unknown opcode with data waiting
        fill(8'h3C);
        p0 = push_n; q0 = pop_n; f0 = flush_n;
        open_frame();
        xfer(8'h12, r);
        for (int i = 0; i < 3; i++) begin
            xfer(8'h70, r);
            check("R9 miso zero", 32'(r), 0);
        end
        close_frame();
        check("R9 no strobes", 32'((push_n - p0) + (pop_n - q0) + (flush_n - f0)), 0);
        open_frame();
        xfer(8'h80, r);
        xfer(8'h00, r);
        close_frame();
        check("R9 fifo intact", 32'(r), 32'h3C);

        // R10: abort mid-byte in push and pop frames
        p0 = push_n;
        open_frame();
        xfer(8'h70, r);
        xfer_bits(8'hE5, 4, r);
        close_frame();
        check("R10 partial push", 32'(push_n - p0), 0);
        fill(8'h91); fill(8'h92);
        q0 = pop_n;
        open_frame();
        xfer(8'h80, r);
        xfer(8'h00, r); check("R10 byte before abort", 32'(r), 32'h91);
        xfer_bits(8'h00, 3, r);
        close_frame();
        check("R10 partial pop", 32'(pop_n - q0), 1);
        dtx_level = 11'h123; drx_level = 11'h456;
        open_frame();
        xfer(8'h60, r);
        word = '0;
        for (int j = 0; j < 4; j++) begin xfer(8'h00, r); word = {word[23:0], r}; end
        close_frame();
        check("R10 opcode after abort", word, {10'b0, 11'h123, 11'h456});
        open_frame();
        xfer(8'h80, r);
        xfer(8'h00, r);
        close_frame();
        check("R10 fifo after abort", 32'(r), 32'h92);

        check("R11 single strobe", 32'(multi_n), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R10 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule